// File: doc/BRIEF.md
# Reference Edge Resynchroniser with Coast Gating

This block accepts a slow, asynchronous line-rate reference pulse (roughly 15 to 280 kHz) and brings it into the pixel-rate sampling clock domain (roughly 12 to 110 MHz). The reference is passed through a two-flop synchroniser. A register bit then selects which edge of the reference counts. Each accepted edge starts an active-low output pulse with a fixed width of `PULSE_W` clocks, 8 by default. Because reference edges are thousands of clocks apart, a fixed-width pulse is a clean, domain-safe copy of the reference.

The same accepted edge drives a one-cycle event toward a phase-frequency detector, together with a level that marks the detector as connected. A coast input is synchronised the same way and can be inverted by a polarity bit. It is used to disconnect the detector during frame flyback or when the reference is missing. The coast state is captured only when an edge is accepted. While coasting, the output pulse is still produced, but the detector event is withheld and the enable level drops.

Top module: `ref_resync`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ref_out_n` is 1, `pfd_event` is 0 and `pfd_enable` is 1.
- R2: With `edge_fall_sel` = 0, a 0-to-1 change of `ref_ain` is accepted. `ref_out_n` goes low at the third rising clock edge that samples the new level, counting the sampling edge as the first. A 1-to-0 change produces no pulse.
- R3: Each accepted edge holds `ref_out_n` low for exactly `PULSE_W` (8) consecutive clock periods, after which it returns to 1.
- R4: With `edge_fall_sel` = 1, a 1-to-0 change of `ref_ain` is accepted with the same latency as in R2, and a 0-to-1 change produces no pulse.
- R5: When the coast state captured at an accepted edge is inactive, `pfd_event` is 1 for exactly the one cycle in which `ref_out_n` first goes low, and `pfd_enable` is 1.
- R6: When the coast state captured at an accepted edge is active, the output pulse still occurs, `pfd_event` stays 0, and `pfd_enable` becomes 0.
- R7: With `coast_low_act` = 0 a high `coast_ain` means coast; with `coast_low_act` = 1 a low `coast_ain` means coast.
- R8: `pfd_enable` changes only in the cycle in which an accepted edge starts a pulse. A change of `coast_ain` between edges has no effect on it until the next accepted edge.
- R9: A selected reference edge detected while `ref_out_n` is low is discarded. The pulse is not lengthened, no event is produced, and no second pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ain | input | 1 | Asynchronous line-rate reference |
| coast_ain | input | 1 | Asynchronous coast request |
| edge_fall_sel | input | 1 | 0 selects the rising reference edge, 1 the falling edge |
| coast_low_act | input | 1 | 0 means coast is active high, 1 means active low |
| ref_out_n | output | 1 | Resynchronised reference, low for `PULSE_W` clocks per accepted edge |
| pfd_enable | output | 1 | Detector connected level, updated at accepted edges |
| pfd_event | output | 1 | One-cycle edge event for the detector |

## Verification
The bench places each pulse edge at its exact cycle. A design with one synchroniser stage too few or too many would move the falling output by a cycle, and a counter off by one would give a width of 7 or 9. The bench also shows that the unselected edge produces nothing, so a detector that fires on both edges is caught. It toggles coast between reference edges and checks that `pfd_enable` does not follow until the next accepted edge; a design that gated the enable level directly would expose the change at once. Finally, it re-arms the reference while a pulse is still running. A retriggerable counter would stretch the low time, and a design that queued the edge would emit a second pulse and event.

// File: rtl/ref_resync_pkg.sv
package ref_resync_pkg;
  // Edge choice applied to the synchronised reference
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  localparam int unsigned DEF_PULSE_W     = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/edge_pick.sv
module edge_pick
  import ref_resync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  edge_mode_e mode,
  output logic       hit
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  always_comb begin
    unique case (mode)
      EDGE_FALL: hit = lvl_d & ~lvl;
      default:   hit = ~lvl_d & lvl;
    endcase
  end
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper #(
  parameter int unsigned PULSE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic coast_act,
  output logic out_n,
  output logic det_en,
  output logic det_evt
);
  localparam int unsigned CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam int unsigned RW = $clog2(PULSE_W + 1) + 1;

  logic [CW-1:0] cnt;
  logic          take;

  // Only an idle shaper accepts an edge; busy-time edges are dropped
  assign take = hit & out_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_n   <= 1'b1;
      cnt     <= '0;
      det_en  <= 1'b1;
      det_evt <= 1'b0;
    end else begin
      det_evt <= 1'b0;
      if (take) begin
        out_n   <= 1'b0;
        cnt     <= CW'(PULSE_W - 1);
        det_en  <= ~coast_act;
        det_evt <= ~coast_act;
      end else if (!out_n) begin
        if (cnt == '0) out_n <= 1'b1;
        else           cnt   <= cnt - 1'b1;
      end
    end
  end

  // Checker: length of the current low run
  logic [RW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)        low_run <= '0;
    else if (!out_n) low_run <= low_run + 1'b1;
    else            low_run <= '0;
  end

  // R3: low run never exceeds PULSE_W
  a_r3_low_bound: assert property (@(posedge clk) disable iff (rst)
    !out_n |-> (low_run <= RW'(PULSE_W - 1)));
  // R3: a finished pulse was exactly PULSE_W long
  a_r3_low_exact: assert property (@(posedge clk) disable iff (rst)
    $rose(out_n) |-> (low_run == RW'(PULSE_W)));
  // R5: event lasts one cycle
  a_r5_evt_single: assert property (@(posedge clk) disable iff (rst)
    det_evt |=> !det_evt);
  // R5, R9: event only at the start of a pulse
  a_r5_evt_at_start: assert property (@(posedge clk) disable iff (rst)
    det_evt |-> $fell(out_n));
  // R6: no event while the detector is disconnected
  a_r6_evt_needs_en: assert property (@(posedge clk) disable iff (rst)
    det_evt |-> det_en);
  // R8: enable level moves only when a pulse starts
  a_r8_en_at_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(det_en) |-> $fell(out_n));
endmodule

// File: rtl/ref_resync.sv
module ref_resync
  import ref_resync_pkg::*;
#(
  parameter int unsigned PULSE_W     = DEF_PULSE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ain,
  input  logic coast_ain,
  input  logic edge_fall_sel,
  input  logic coast_low_act,
  output logic ref_out_n,
  output logic pfd_enable,
  output logic pfd_event
);
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic       ref_lvl;
  logic       coast_lvl;
  logic       coast_act;
  logic       hit;
  edge_mode_e mode;

  assign raw_in = {coast_ain, ref_ain};

  sync_chain #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  assign ref_lvl   = synced[0];
  assign coast_lvl = synced[1];
  assign coast_act = coast_lvl ^ coast_low_act;
  assign mode      = edge_mode_e'(edge_fall_sel);

  edge_pick u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (ref_lvl),
    .mode (mode),
    .hit  (hit)
  );

  pulse_shaper #(
    .PULSE_W (PULSE_W)
  ) u_shape (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .coast_act (coast_act),
    .out_n     (ref_out_n),
    .det_en    (pfd_enable),
    .det_evt   (pfd_event)
  );

  // R1: outputs idle one cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (ref_out_n && !pfd_event && pfd_enable));
endmodule

// File: tb/sim_ref_resync.sv
module sim_ref_resync;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_ain = 1'b0, coast_ain = 1'b0, edge_fall_sel = 1'b0, coast_low_act = 1'b0;
  logic ref_out_n, pfd_enable, pfd_event;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  ref_resync u0 (
    .clk(clk), .rst(rst), .ref_ain(ref_ain), .coast_ain(coast_ain),
    .edge_fall_sel(edge_fall_sel), .coast_low_act(coast_low_act),
    .ref_out_n(ref_out_n), .pfd_enable(pfd_enable), .pfd_event(pfd_event)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called just after the stimulus edge is driven at a negedge
  task automatic expect_pulse(input logic exp_evt, input logic exp_en, input string req);
    for (int i = 1; i <= 11; i++) begin
      step(1);
      if (i <= 2) begin
        chk({req, " pre-latency high"}, ref_out_n, 1'b1);
        chk({req, " no early event"}, pfd_event, 1'b0);
      end else if (i == 3) begin
        chk({req, " R2 start low"}, ref_out_n, 1'b0);
        chk({req, " R5 event at start"}, pfd_event, exp_evt);
        chk({req, " enable at start"}, pfd_enable, exp_en);
      end else if (i <= 10) begin
        chk({req, " R3 held low"}, ref_out_n, 1'b0);
        chk({req, " R5 event single"}, pfd_event, 1'b0);
      end else begin
        chk({req, " R3 high after width"}, ref_out_n, 1'b1);
      end
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1);
      chk({req, " output stays high"}, ref_out_n, 1'b1);
      chk({req, " no event"}, pfd_event, 1'b0);
    end
  endtask

  task automatic t_reset;
    step(1);
    chk("R1 out in reset", ref_out_n, 1'b1);
    chk("R1 event in reset", pfd_event, 1'b0);
    chk("R1 enable in reset", pfd_enable, 1'b1);
    rst = 1'b0;
    step(1);
    chk("R1 out after reset", ref_out_n, 1'b1);
    chk("R1 enable after reset", pfd_enable, 1'b1);
    step(10);
  endtask

  task automatic t_rise;
    edge_fall_sel = 1'b0;
    step(4);
    ref_ain = 1'b1;
    expect_pulse(1'b1, 1'b1, "R2 rising");
    step(10);
    ref_ain = 1'b0;
    expect_quiet(20, "R2 falling ignored");
  endtask

  task automatic t_fall;
    edge_fall_sel = 1'b1;
    step(4);
    ref_ain = 1'b1;
    expect_quiet(20, "R4 rising ignored");
    ref_ain = 1'b0;
    expect_pulse(1'b1, 1'b1, "R4 falling");
    step(10);
    edge_fall_sel = 1'b0;
    step(4);
  endtask

  task automatic t_coast;
    coast_low_act = 1'b0;
    coast_ain = 1'b1;
    step(6);
    ref_ain = 1'b1;
    expect_pulse(1'b0, 1'b0, "R6 coasting");
    chk("R6 enable low after coast edge", pfd_enable, 1'b0);
    step(5);
    ref_ain = 1'b0;
    coast_ain = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      chk("R8 enable held until next edge", pfd_enable, 1'b0);
    end
    ref_ain = 1'b1;
    expect_pulse(1'b1, 1'b1, "R8 coast released");
    step(5);
    ref_ain = 1'b0;
    step(10);
  endtask

  task automatic t_polarity;
    coast_low_act = 1'b1;
    coast_ain = 1'b0;
    step(6);
    ref_ain = 1'b1;
    expect_pulse(1'b0, 1'b0, "R7 low coast active");
    step(5);
    ref_ain = 1'b0;
    coast_ain = 1'b1;
    step(10);
    chk("R8 enable unchanged between edges", pfd_enable, 1'b0);
    ref_ain = 1'b1;
    expect_pulse(1'b1, 1'b1, "R7 high coast inactive");
    step(5);
    ref_ain = 1'b0;
    coast_low_act = 1'b0;
    coast_ain = 1'b0;
    step(10);
  endtask

  task automatic t_retrigger;
    int low_cnt = 0;
    int evt_cnt = 0;
    edge_fall_sel = 1'b0;
    ref_ain = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      step(1);
      if (i == 4) ref_ain = 1'b0;
      if (i == 5) ref_ain = 1'b1;
      if (!ref_out_n) low_cnt++;
      if (pfd_event) evt_cnt++;
      if (i == 11) chk("R9 pulse not extended", ref_out_n, 1'b1);
    end
    chk("R9 total low cycles", low_cnt, 8);
    chk("R9 single event", evt_cnt, 1);
    ref_ain = 1'b0;
    step(10);
  endtask

  initial begin
    step(3);
    t_reset();
    t_rise();
    t_fall();
    t_coast();
    t_polarity();
    t_retrigger();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule